// File: doc/BRIEF.md
# Standby Mode Controller

This block decides which clock domains of a small single-clock microcontroller may run. It runs on the gear clock and drives clock enables for the CPU, the watchdog, the general peripherals and the time base timer. It has three modes. In run mode everything is clocked. In light idle the CPU and the watchdog are held and the peripherals keep running. In deep idle only the time base timer keeps its clock. A gated peripheral keeps its register contents, because its enable is held low and no reset is applied.

Software picks an idle depth by writing one of two request bits while the block is in run mode. Light idle ends when an interrupt latch that is individually enabled is set. Deep idle ends on a falling edge of the time-base source clock chosen by the select input. This wake happens whether or not the timer is enabled. On wake the block tells the CPU whether to service an interrupt or to resume at the instruction after the one that entered idle. After a deep wake it can also pulse the set input of the time-base interrupt latch.

Top module: `standby_ctrl`

## Requirements
- R1: While reset is held and after it is released, the mode is RUN (mode = 0). All four clock enables are 1, and both request bits, `wake_pulse`, `wake_service` and `tbt_latch_set` are 0.
- R2: A write in RUN with `wr_light`=1 and `wr_deep`=0 enters light idle (mode = 1) at the next clock edge. In light idle `cpu_ce`=0, `wdt_ce`=0, `periph_ce`=1 and `tbt_ce`=1.
- R3: In light idle, if any bit of `irq_latch & irq_enable` is 1, the mode returns to RUN at the next edge and all enables go back to 1. A latch bit whose enable bit is 0 does not end light idle.
- R4: `wake_pulse` is 1 for exactly the one cycle in which the mode first reads RUN after a wake. In that cycle `wake_service` is 1 when an interrupt is to be serviced and 0 when execution resumes at the next instruction.
- R5: A light-idle wake reports `wake_service` = `master_ie`.
- R6: A write in RUN with `wr_deep`=1 enters deep idle (mode = 2) at the next edge. In deep idle `cpu_ce`, `wdt_ce` and `periph_ce` are 0 and `tbt_ce` is 1. When both request bits are written as 1 together, deep idle is chosen.
- R7: Deep idle ends on a falling edge of `tb_src[tb_sel]`. The source is synchronized by two flops and then edge detected. If the source falls just after edge k, the mode reads RUN after edge k+3 and still reads deep after edge k+2. The wake occurs whatever the value of `tb_enable`.
- R8: In deep idle, interrupt latches and edges on unselected sources do not end idle.
- R9: If `tb_enable` was 1 at the edge that entered deep idle, `tbt_latch_set` pulses for one cycle, one cycle after the mode reads RUN. Later changes to `tb_enable` do not affect this. If `tb_enable` was 0 at entry, no pulse is produced.
- R10: A deep wake reports `wake_service` = `master_ie & tbt_ie & (tb_enable captured at entry)`.
- R11: The request bits `req_light`/`req_deep` read 1 exactly while the mode is light/deep idle, and they clear on wake.
- R12: Writes made while the block is in either idle mode are ignored: mode and enables stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Gear clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe |
| wr_light | input | 1 | Light-idle request bit value written |
| wr_deep | input | 1 | Deep-idle request bit value written |
| irq_latch | input | N_IRQ | Interrupt latch states |
| irq_enable | input | N_IRQ | Individual interrupt enables |
| master_ie | input | 1 | Master interrupt enable flag |
| tbt_ie | input | 1 | Individual enable of the time-base interrupt |
| tb_enable | input | 1 | Time base timer enable |
| tb_src | input | N_SRC | Candidate time-base source clocks, asynchronous |
| tb_sel | input | SEL_W | Time-base source select |
| mode | output | 2 | 0 run, 1 light idle, 2 deep idle |
| cpu_ce | output | 1 | CPU clock enable |
| wdt_ce | output | 1 | Watchdog clock enable |
| periph_ce | output | 1 | General peripheral clock enable |
| tbt_ce | output | 1 | Time base timer clock enable |
| req_light | output | 1 | Light-idle request bit |
| req_deep | output | 1 | Deep-idle request bit |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_service | output | 1 | 1: service interrupt; 0: resume next instruction |
| tbt_latch_set | output | 1 | One-cycle set pulse for the time-base interrupt latch |

## Verification
A corrupted mode register shows at once in the enable pattern, because every enable is registered from the same next-state value as the mode. A stale synchronizer stage shifts deep-idle wake by a whole cycle, so the bench samples the cycles just before and just after the expected edge. A lost copy of the timer enable at entry shows only one cycle after the return to run mode, as a missing or spurious latch-set pulse. The bench changes the enable during idle to expose a design that reads it live.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_LIGHT = 2'd1,
    MODE_DEEP  = 2'd2
  } sbc_mode_e;
endpackage

// File: rtl/sbc_fall_sync.sv
module sbc_fall_sync #(
  parameter int N_SRC = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src,
  input  logic [SEL_W-1:0] sel,
  output logic             fall_o
);
  logic [N_SRC-1:0] fall_vec;

  // per source: two synchronizer flops plus a history flop
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic [2:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= 3'b111;
      else     pipe <= {pipe[1:0], src[g]};
    end
    assign fall_vec[g] = pipe[2] & ~pipe[1];
  end

  always_comb begin
    fall_o = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (sel == SEL_W'(i)) fall_o = fall_vec[i];
  end
endmodule

// File: rtl/sbc_wake_eval.sv
module sbc_wake_eval
  import sbc_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  sbc_mode_e        mode,
  input  logic [N_IRQ-1:0] irq_latch,
  input  logic [N_IRQ-1:0] irq_enable,
  input  logic             tb_fall,
  input  logic             master_ie,
  input  logic             tbt_ie,
  input  logic             tbt_armed,
  output logic             wake,
  output logic             deep_wake,
  output logic             service
);
  logic irq_hit;
  assign irq_hit   = |(irq_latch & irq_enable);
  assign deep_wake = (mode == MODE_DEEP) && tb_fall;
  assign wake      = ((mode == MODE_LIGHT) && irq_hit) || deep_wake;

  always_comb begin
    case (mode)
      MODE_LIGHT: service = master_ie;
      MODE_DEEP:  service = master_ie & tbt_ie & tbt_armed;
      default:    service = 1'b0;
    endcase
  end
endmodule

// File: rtl/sbc_mode_fsm.sv
module sbc_mode_fsm
  import sbc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  logic      wr_light,
  input  logic      wr_deep,
  input  logic      tb_enable,
  input  logic      wake,
  input  logic      deep_wake,
  input  logic      service,
  output sbc_mode_e mode_q,
  output logic      tbt_armed,
  output logic      cpu_ce,
  output logic      wdt_ce,
  output logic      periph_ce,
  output logic      tbt_ce,
  output logic      req_light,
  output logic      req_deep,
  output logic      wake_pulse,
  output logic      wake_service,
  output logic      tbt_latch_set
);
  sbc_mode_e mode_d;
  logic      tbt_pend;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      MODE_RUN: begin
        if (wr_en && wr_deep)       mode_d = MODE_DEEP;
        else if (wr_en && wr_light) mode_d = MODE_LIGHT;
      end
      MODE_LIGHT, MODE_DEEP: begin
        if (wake) mode_d = MODE_RUN;
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q        <= MODE_RUN;
      cpu_ce        <= 1'b1;
      wdt_ce        <= 1'b1;
      periph_ce     <= 1'b1;
      tbt_ce        <= 1'b1;
      req_light     <= 1'b0;
      req_deep      <= 1'b0;
      wake_pulse    <= 1'b0;
      wake_service  <= 1'b0;
      tbt_armed     <= 1'b0;
      tbt_pend      <= 1'b0;
      tbt_latch_set <= 1'b0;
    end else begin
      mode_q        <= mode_d;
      cpu_ce        <= (mode_d == MODE_RUN);
      wdt_ce        <= (mode_d == MODE_RUN);
      periph_ce     <= (mode_d != MODE_DEEP);
      tbt_ce        <= 1'b1;
      req_light     <= (mode_d == MODE_LIGHT);
      req_deep      <= (mode_d == MODE_DEEP);
      wake_pulse    <= wake;
      wake_service  <= wake & service;
      if (mode_q == MODE_RUN && mode_d == MODE_DEEP) tbt_armed <= tb_enable;
      tbt_pend      <= deep_wake & tbt_armed;
      tbt_latch_set <= tbt_pend;
    end
  end

  // R2 light idle enable pattern
  a_r2_light_ce: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LIGHT) |-> (!cpu_ce && !wdt_ce && periph_ce && tbt_ce));
  // R6 deep idle enable pattern
  a_r6_deep_ce: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_DEEP) |-> (!cpu_ce && !wdt_ce && !periph_ce && tbt_ce));
  // R6 deep wins when both bits written
  a_r6_deep_priority: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RUN && wr_en && wr_deep && wr_light) |=> (mode_q == MODE_DEEP));
  // R4 wake pulse lands in run mode with requests cleared
  a_r4_wake_in_run: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (mode_q == MODE_RUN && cpu_ce && !req_light && !req_deep));
  // R4 single-cycle wake pulse
  a_r4_wake_single: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);
  // R9 latch set only one cycle into run mode
  a_r9_latch_after_run: assert property (@(posedge clk) disable iff (rst)
    tbt_latch_set |-> (mode_q == MODE_RUN && $past(mode_q == MODE_RUN) && !wake_pulse));
  // R11 request bits track idle mode
  a_r11_req_track: assert property (@(posedge clk) disable iff (rst)
    (req_light == (mode_q == MODE_LIGHT)) && (req_deep == (mode_q == MODE_DEEP)));
  // R12 idle mode held until wake
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_RUN && !wake) |=> $stable(mode_q));
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import sbc_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int N_SRC = 4,
  parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_light,
  input  logic             wr_deep,
  input  logic [N_IRQ-1:0] irq_latch,
  input  logic [N_IRQ-1:0] irq_enable,
  input  logic             master_ie,
  input  logic             tbt_ie,
  input  logic             tb_enable,
  input  logic [N_SRC-1:0] tb_src,
  input  logic [SEL_W-1:0] tb_sel,
  output logic [1:0]       mode,
  output logic             cpu_ce,
  output logic             wdt_ce,
  output logic             periph_ce,
  output logic             tbt_ce,
  output logic             req_light,
  output logic             req_deep,
  output logic             wake_pulse,
  output logic             wake_service,
  output logic             tbt_latch_set
);
  sbc_mode_e mode_q;
  logic      tb_fall;
  logic      wake;
  logic      deep_wake;
  logic      service;
  logic      tbt_armed;

  sbc_fall_sync #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_fall (
    .clk(clk), .rst(rst), .src(tb_src), .sel(tb_sel), .fall_o(tb_fall)
  );

  sbc_wake_eval #(.N_IRQ(N_IRQ)) u_eval (
    .mode(mode_q), .irq_latch(irq_latch), .irq_enable(irq_enable),
    .tb_fall(tb_fall), .master_ie(master_ie), .tbt_ie(tbt_ie),
    .tbt_armed(tbt_armed), .wake(wake), .deep_wake(deep_wake),
    .service(service)
  );

  sbc_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_light(wr_light),
    .wr_deep(wr_deep), .tb_enable(tb_enable), .wake(wake),
    .deep_wake(deep_wake), .service(service), .mode_q(mode_q),
    .tbt_armed(tbt_armed), .cpu_ce(cpu_ce), .wdt_ce(wdt_ce),
    .periph_ce(periph_ce), .tbt_ce(tbt_ce), .req_light(req_light),
    .req_deep(req_deep), .wake_pulse(wake_pulse),
    .wake_service(wake_service), .tbt_latch_set(tbt_latch_set)
  );

  assign mode = mode_q;

  // R3 enabled latch in light idle always wakes
  a_r3_light_wake: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LIGHT && |(irq_latch & irq_enable)) |=> (mode_q == MODE_RUN && wake_pulse));
  // R8 interrupts alone never end deep idle
  a_r8_deep_irq_ignored: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_DEEP && !tb_fall) |=> (mode_q == MODE_DEEP));
endmodule

// File: tb/standby_ctrl_tb.sv
module standby_ctrl_tb_top;
  localparam int N_IRQ = 8;
  localparam int N_SRC = 4;
  localparam int SEL_W = 2;

  logic clk = 1'b0;
  logic rst;
  logic wr_en, wr_light, wr_deep;
  logic [N_IRQ-1:0] irq_latch, irq_enable;
  logic master_ie, tbt_ie, tb_enable;
  logic [N_SRC-1:0] tb_src;
  logic [SEL_W-1:0] tb_sel;
  logic [1:0] mode;
  logic cpu_ce, wdt_ce, periph_ce, tbt_ce, req_light, req_deep;
  logic wake_pulse, wake_service, tbt_latch_set;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  standby_ctrl #(.N_IRQ(N_IRQ), .N_SRC(N_SRC), .SEL_W(SEL_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_light(wr_light), .wr_deep(wr_deep),
    .irq_latch(irq_latch), .irq_enable(irq_enable), .master_ie(master_ie),
    .tbt_ie(tbt_ie), .tb_enable(tb_enable), .tb_src(tb_src), .tb_sel(tb_sel),
    .mode(mode), .cpu_ce(cpu_ce), .wdt_ce(wdt_ce), .periph_ce(periph_ce),
    .tbt_ce(tbt_ce), .req_light(req_light), .req_deep(req_deep),
    .wake_pulse(wake_pulse), .wake_service(wake_service),
    .tbt_latch_set(tbt_latch_set)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // enable vector packed as {cpu,wdt,periph,tbt}
  function automatic int ces();
    return {cpu_ce, wdt_ce, periph_ce, tbt_ce};
  endfunction

  task automatic do_write(input logic l, input logic d);
    wr_en = 1'b1; wr_light = l; wr_deep = d;
    tick();
    wr_en = 1'b0; wr_light = 1'b0; wr_deep = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(3);
    check("R1 mode in reset", mode, 0);
    check("R1 enables in reset", ces(), 15);
    rst = 1'b0;
    tick();
    check("R1 mode after reset", mode, 0);
    check("R1 enables after reset", ces(), 15);
    check("R1 flags after reset",
          {req_light, req_deep, wake_pulse, wake_service, tbt_latch_set}, 0);
  endtask

  task automatic t_light(input logic ie);
    master_ie = ie;
    do_write(1'b1, 1'b0);
    check("R2 light mode", mode, 1);
    check("R2 light enables", ces(), 3);
    check("R11 req_light set", {req_light, req_deep}, 2);
    // latch set but not enabled: stays idle
    irq_latch = 8'h10; irq_enable = 8'h01;
    tick(2);
    check("R3 unenabled latch ignored", mode, 1);
    // write during idle ignored
    do_write(1'b0, 1'b1);
    check("R12 write in light ignored", mode, 1);
    check("R12 light enables kept", ces(), 3);
    irq_enable = 8'h11;
    tick();
    check("R3 light wake mode", mode, 0);
    check("R3 enables restored", ces(), 15);
    check("R4 wake pulse", wake_pulse, 1);
    check("R5 light service", wake_service, int'(ie));
    check("R11 req cleared", {req_light, req_deep}, 0);
    irq_latch = '0; irq_enable = '0;
    tick();
    check("R4 wake pulse single", wake_pulse, 0);
  endtask

  task automatic t_deep(input logic ten, input logic ie, input logic tie,
                        input logic both, input logic [SEL_W-1:0] sel);
    master_ie = ie; tbt_ie = tie; tb_enable = ten; tb_sel = sel;
    do_write(both, 1'b1);
    check("R6 deep mode", mode, 2);
    check("R6 deep enables", ces(), 1);
    check("R11 req_deep set", {req_light, req_deep}, 1);
    tb_enable = ~ten;  // later change must not matter
    irq_latch = 8'hFF; irq_enable = 8'hFF;
    tb_src[sel + 2'd1] = 1'b0;  // unselected source falls
    tick(4);
    check("R8 deep ignores irq and other source", mode, 2);
    check("R8 deep enables held", ces(), 1);
    tb_src = '1;
    tick(3);
    tb_src[sel] = 1'b0;
    tick(2);
    check("R7 still deep after two edges", mode, 2);
    tick();
    check("R7 wake after three edges", mode, 0);
    check("R7 enables restored", ces(), 15);
    check("R4 deep wake pulse", wake_pulse, 1);
    check("R10 deep service", wake_service, int'(ie & tie & ten));
    check("R9 no latch set in wake cycle", tbt_latch_set, 0);
    irq_latch = '0; irq_enable = '0;
    tick();
    check("R9 latch set pulse", tbt_latch_set, int'(ten));
    tick();
    check("R9 latch pulse single", tbt_latch_set, 0);
    tb_src = '1;
    tick(3);
  endtask

  initial begin
    rst = 1'b1; wr_en = 0; wr_light = 0; wr_deep = 0;
    irq_latch = '0; irq_enable = '0; master_ie = 0; tbt_ie = 0;
    tb_enable = 0; tb_src = '1; tb_sel = '0;
    @(negedge clk);
    t_reset();
    t_light(1'b0);
    t_light(1'b1);
    t_deep(1'b0, 1'b1, 1'b1, 1'b0, 2'd0);
    t_deep(1'b1, 1'b1, 1'b1, 1'b0, 2'd2);
    t_deep(1'b1, 1'b0, 1'b1, 1'b1, 2'd1);  // both bits: deep priority
    t_deep(1'b1, 1'b1, 1'b0, 1'b0, 2'd3);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule